// File: doc/BRIEF.md
# SDRAM Command and Initialization Sequencer

This block issues the command-pin sequences that bring a single-data-rate SDRAM out of power-up and keep it refreshed. A host writes a command word into a small register file. The word holds a mode code, one target bit per chip select, an auto-refresh repeat count and a mode-register value. The sequencer drives the matching pattern on CS#, RAS#, CAS#, WE# and the address bus. It then holds the bus in NOP for the wait programmed in the timing register. A busy flag in the status word stays high until the whole sequence has finished.

Software brings the memory up with these commands in order: clock enable, a wait of at least 200 µs, precharge-all, a burst of auto-refreshes, a mode-register load, and finally normal mode. Once normal mode is active, a down-counter reloads from the programmed refresh count and issues one auto-refresh each time it expires. The control word, which sets geometry, width, CAS latency, write protect, clock divisor and read options, is stored and read back for the datapath. The sequencer itself does not interpret it.

Register map (3-bit word address): 0 control, 1 timing, 2 command, 3 refresh, 4 status. Unmapped addresses read as zero.

Top module: `sdr_cmd_seq`

## Requirements
- R1: After reset, sd_cke is 0, every chip select is high, RAS#/CAS#/WE# are high, sd_addr is 0, status reads 0, and the refresh word reads 8196 shifted left by one (16392).
- R2: Control (address 0) keeps write bits 14:0. Timing (address 1) keeps bits 27:0. Refresh (address 3) keeps bits 14:1. Command (address 2) reads back bits 21:0 of the last accepted command. All other bits read 0.
- R3: The command mode is bits 2:0 (0 normal, 1 clock enable, 2 precharge all, 3 auto-refresh, 4 load mode, 5 self-refresh, 6 power-down). Bit 4 selects chip select 0 (sd_cs_n[0]) and bit 3 selects chip select 1 (sd_cs_n[1]). Only the selected chip selects go low. A command with mode 7 or with no target bit set is ignored. While idle, all chip selects are high.
- R4: Status bit 5 is 1 from the cycle after a command is accepted until its last cycle. A command written while busy is ignored. Two command cycles are never back to back.
- R5: Clock enable raises sd_cke in the cycle after acceptance, with one NOP busy cycle, and sd_cke then stays high until reset.
- R6: Precharge all drives one cycle of CS#,RAS#,CAS#,WE# = L,L,H,L with sd_addr bit 10 high. This is followed by tRP NOP cycles, where tRP is timing bits 23:20.
- R7: Auto-refresh issues N+1 refreshes, where N is command bits 8:5. Each refresh is one cycle of L,L,L,H followed by tRC+1 NOP cycles, where tRC is timing bits 15:12.
- R8: Load mode drives one cycle of L,L,L,L with sd_addr equal to command bits 21:9 (burst length at value bit 0, CAS latency from value bit 4). This is followed by tMRD NOP cycles, where tMRD is timing bits 3:0.
- R9: Normal, self-refresh and power-down each take a single busy cycle of NOP on the targeted chip selects and drive no other pin.
- R10: While normal mode is active, a counter reloads from refresh bits 14:1 and issues one auto-refresh to the normal-mode targets after every count+1 cycles. Accepting any other host command leaves normal mode.
- R11: A refresh expiry that finds the sequencer busy, or that coincides with an accepted host command, is dropped.
- R12: Wait lengths are taken from the timing register when the command is accepted. A later timing write does not change a running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 2 | Chip selects, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | SDRAM address bus (bit 10 = all-banks, mode value) |

## Verification
The assertions assume reset is asserted only at the start of a run, so the sticky clock-enable property never sees a mid-run reset. They also assume reg_wr and reg_addr are never unknown once reset is released. The bench keeps to this: it applies reset once, and after that it drives only defined values from a single task at the falling edge. The spacing property holds only because every refresh is followed by at least one NOP. The stimulus reaches the other tight spacing cases by programming zero tRP and zero tMRD and then issuing host commands back to back. It also sets the refresh count small so that timer expiries collide with running sequences.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  localparam int SD_ADDR_W   = 13;
  localparam int NCS         = 2;
  localparam int TF_W        = 4;
  localparam int REF_W       = 14;
  localparam int REF_DEFAULT = 8196;
  localparam int CMD_W       = 9 + SD_ADDR_W;
  localparam int BANK_TOP    = 4;
  localparam int NREF_LSB    = 5;
  localparam int NREF_W      = 4;
  localparam int MVAL_LSB    = 9;
  localparam int BUSY_BIT    = 5;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_TIM  = 3'd1;
  localparam logic [2:0] A_CMD  = 3'd2;
  localparam logic [2:0] A_REF  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  typedef enum logic [2:0] {
    M_NORMAL = 3'd0, M_CLKEN = 3'd1, M_PREALL = 3'd2, M_AREF = 3'd3,
    M_LOADMR = 3'd4, M_SELFREF = 3'd5, M_PWRDN = 3'd6, M_RSVD = 3'd7
  } sdr_mode_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} sdr_state_e;
  typedef enum logic [1:0] {K_NOP, K_PRE, K_REF, K_LMR} sdr_kind_e;
endpackage

// File: rtl/sdr_regs.sv
module sdr_regs
  import sdr_seq_pkg::*;
#(
  parameter int RW = REF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  input  logic              cmd_accept,
  input  logic              busy,
  output logic [27:0]       tim_q,
  output logic [RW-1:0]     ref_cnt,
  output logic [31:0]       rdata
);
  logic [14:0]      ctrl_q, ctrl_d;
  logic [27:0]      tim_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic [RW-1:0]    ref_d;
  logic             unused_hi;

  assign unused_hi = ^wdata[31:28];

  always_comb begin
    ctrl_d = ctrl_q;
    tim_d  = tim_q;
    cmd_d  = cmd_q;
    ref_d  = ref_cnt;
    if (wr && addr == A_CTRL) ctrl_d = wdata[14:0];
    if (wr && addr == A_TIM)  tim_d  = wdata[27:0];
    if (wr && addr == A_REF)  ref_d  = wdata[RW:1];
    if (cmd_accept)           cmd_d  = wdata[CMD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      tim_q   <= '0;
      cmd_q   <= '0;
      ref_cnt <= RW'(REF_DEFAULT);
    end else begin
      ctrl_q  <= ctrl_d;
      tim_q   <= tim_d;
      cmd_q   <= cmd_d;
      ref_cnt <= ref_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[14:0]      = ctrl_q;
      A_TIM:   rdata[27:0]      = tim_q;
      A_CMD:   rdata[CMD_W-1:0] = cmd_q;
      A_REF:   rdata[RW:1]      = ref_cnt;
      A_STAT:  rdata[BUSY_BIT]  = busy;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
  parameter int RW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] reload,
  output logic          req
);
  logic [RW-1:0] cnt_q, cnt_d;

  always_comb begin
    req   = run && (cnt_q == '0);
    cnt_d = (!run || cnt_q == '0) ? reload : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sdr_cmd_fsm.sv
module sdr_cmd_fsm
  import sdr_seq_pkg::*;
#(
  parameter int AW = SD_ADDR_W,
  parameter int TW = TF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_go,
  input  logic [CMD_W-1:0]   host_cmd,
  input  logic [TW-1:0]      t_rp,
  input  logic [TW-1:0]      t_rc,
  input  logic [TW-1:0]      t_mrd,
  input  logic               ref_req,
  output logic               accept,
  output logic               busy,
  output logic               normal,
  output logic               cke,
  output logic [NCS-1:0]     cs_n,
  output logic               ras_n,
  output logic               cas_n,
  output logic               we_n,
  output logic [AW-1:0]      addr
);
  localparam int WW = TW + 1;

  sdr_state_e        state_q, state_d;
  sdr_kind_e         kind_q, kind_d;
  logic [NCS-1:0]    banks_q, banks_d, nbank_q, nbank_d, hbanks;
  logic [WW-1:0]     wlen_q, wlen_d, cnt_q, cnt_d;
  logic [NREF_W-1:0] reps_q, reps_d;
  logic [AW-1:0]     mval_q, mval_d;
  logic              cke_q, cke_d, norm_q, norm_d;
  sdr_mode_e         mode;
  logic              host_ok, auto_go;
  logic [WW-1:0]     rc_wait;

  for (genvar g = 0; g < NCS; g++) begin : g_tgt
    assign hbanks[g] = host_cmd[BANK_TOP-g];
  end

  assign mode    = sdr_mode_e'(host_cmd[2:0]);
  assign host_ok = host_go && (mode != M_RSVD) && (hbanks != '0);
  assign accept  = (state_q == ST_IDLE) && host_ok;
  assign auto_go = (state_q == ST_IDLE) && !host_ok && ref_req;
  assign rc_wait = {1'b0, t_rc} + 1'b1;

  always_comb begin
    state_d = state_q; kind_d = kind_q; banks_d = banks_q; nbank_d = nbank_q;
    wlen_d  = wlen_q;  cnt_d  = cnt_q;  reps_d  = reps_q;  mval_d  = mval_q;
    cke_d   = cke_q;   norm_d = norm_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_ISSUE;
          banks_d = hbanks;
          mval_d  = host_cmd[MVAL_LSB +: AW];
          reps_d  = '0;
          wlen_d  = '0;
          kind_d  = K_NOP;
          norm_d  = (mode == M_NORMAL);
          if (mode == M_NORMAL) nbank_d = hbanks;
          case (mode)
            M_CLKEN:  cke_d = 1'b1;
            M_PREALL: begin kind_d = K_PRE; wlen_d = {1'b0, t_rp}; end
            M_AREF:   begin kind_d = K_REF; wlen_d = rc_wait;
                            reps_d = host_cmd[NREF_LSB +: NREF_W]; end
            M_LOADMR: begin kind_d = K_LMR; wlen_d = {1'b0, t_mrd}; end
            default:  kind_d = K_NOP;
          endcase
        end else if (auto_go) begin
          state_d = ST_ISSUE;
          banks_d = nbank_q;
          kind_d  = K_REF;
          reps_d  = '0;
          wlen_d  = rc_wait;
        end
      end
      ST_ISSUE: begin
        if (wlen_q != '0) begin
          state_d = ST_WAIT;
          cnt_d   = wlen_q - 1'b1;
        end else if (reps_q != '0) begin
          reps_d = reps_q - 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (reps_q != '0) begin
          reps_d  = reps_q - 1'b1;
          state_d = ST_ISSUE;
        end else begin
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; kind_q <= K_NOP; banks_q <= '0; nbank_q <= '0;
      wlen_q  <= '0;      cnt_q  <= '0;    reps_q  <= '0; mval_q  <= '0;
      cke_q   <= 1'b0;    norm_q <= 1'b0;
    end else begin
      state_q <= state_d; kind_q <= kind_d; banks_q <= banks_d; nbank_q <= nbank_d;
      wlen_q  <= wlen_d;  cnt_q  <= cnt_d;  reps_q  <= reps_d;  mval_q  <= mval_d;
      cke_q   <= cke_d;   norm_q <= norm_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign normal = norm_q;
  assign cke    = cke_q;

  always_comb begin
    cs_n  = '1;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    addr  = '0;
    if (busy) cs_n = ~banks_q;
    if (state_q == ST_ISSUE) begin
      case (kind_q)
        K_PRE:   begin ras_n = 1'b0; we_n = 1'b0; addr[10] = 1'b1; end
        K_REF:   begin ras_n = 1'b0; cas_n = 1'b0; end
        K_LMR:   begin ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; addr = mval_q; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
  import sdr_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [2:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 sd_cke,
  output logic [NCS-1:0]       sd_cs_n,
  output logic                 sd_ras_n,
  output logic                 sd_cas_n,
  output logic                 sd_we_n,
  output logic [SD_ADDR_W-1:0] sd_addr
);
  logic [1:0]       rst_sync;
  logic             rst_i_n;
  logic             busy, accept, normal, ref_req;
  logic [27:0]      tim_q;
  logic [REF_W-1:0] ref_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  sdr_regs #(.RW(REF_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cmd_accept(accept), .busy(busy), .tim_q(tim_q), .ref_cnt(ref_cnt),
    .rdata(reg_rdata)
  );

  sdr_ref_timer #(.RW(REF_W)) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .run(normal), .reload(ref_cnt), .req(ref_req)
  );

  sdr_cmd_fsm #(.AW(SD_ADDR_W), .TW(TF_W)) u_fsm (
    .clk(clk), .rst_n(rst_i_n),
    .host_go(reg_wr && reg_addr == A_CMD), .host_cmd(reg_wdata[CMD_W-1:0]),
    .t_rp(tim_q[23:20]), .t_rc(tim_q[15:12]), .t_mrd(tim_q[3:0]),
    .ref_req(ref_req), .accept(accept), .busy(busy), .normal(normal),
    .cke(sd_cke), .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n),
    .we_n(sd_we_n), .addr(sd_addr)
  );
endmodule

// File: rtl/sdr_seq_chk.sv
module sdr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       sd_cke,
  input logic [1:0] sd_cs_n,
  input logic       sd_ras_n,
  input logic       sd_cas_n,
  input logic       sd_we_n,
  input logic       a10
);
  logic cmd_cyc;
  assign cmd_cyc = !(sd_ras_n && sd_cas_n && sd_we_n);

  // R3: no chip select while idle
  a_r3_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sd_cs_n == 2'b11);

  // R4: pins move only inside a busy sequence, never two command cycles in a row
  a_r4_cmd_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cyc |-> busy);
  a_r4_cmd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cyc |=> !cmd_cyc);

  // R5: clock enable is sticky
  a_r5_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke |=> sd_cke);

  // R6: precharge always addresses all banks
  a_r6_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_ras_n && sd_cas_n && !sd_we_n) |-> a10);
endmodule

bind sdr_cmd_seq sdr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .a10(sd_addr[10])
);

// File: tb/sdr_cmd_seq_tb.sv
module sdr_cmd_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i_wr = 1'b0;
  logic [2:0]  i_addr = 3'd3;
  logic [31:0] i_wdata = '0;
  logic [31:0] rdata;
  logic        cke, ras_n, cas_n, we_n;
  logic [1:0]  cs_n;
  logic [12:0] sdaddr;

  int nvec = 0, nbad = 0;

  always #2.5 clk = ~clk;

  sdr_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(i_wr), .reg_addr(i_addr), .reg_wdata(i_wdata),
    .reg_rdata(rdata), .sd_cke(cke), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
    .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_addr(sdaddr)
  );

  // reference model state
  logic [17:0] q[$];
  string       tq[$];
  logic [31:0] m_ctrl = 0, m_tim = 0, m_cmd = 0;
  int          m_refcnt = 8196, m_tmr = 0;
  bit          m_cke = 0, m_norm = 0;
  logic [1:0]  m_nb = 0;
  localparam logic [17:0] IDLE_PAT = {2'b11, 3'b111, 13'd0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] hb, input logic [2:0] rcw, input logic [12:0] a,
                       input int w, input int reps, input string tag);
    for (int r = 0; r <= reps; r++) begin
      q.push_back({~hb, rcw, a}); tq.push_back(tag);
      for (int j = 0; j < w; j++) begin
        q.push_back({~hb, 3'b111, 13'd0}); tq.push_back(tag);
      end
    end
  endtask

  task automatic model_edge();
    bit was_idle, req;
    logic [1:0] hb;
    logic [2:0] md;
    int trp, trc, tmrd;
    was_idle = (q.size() == 0);
    if (!was_idle) begin void'(q.pop_front()); void'(tq.pop_front()); end
    req = m_norm && m_tmr == 0;
    if (!m_norm || m_tmr == 0) m_tmr = m_refcnt; else m_tmr--;
    hb = {i_wdata[3], i_wdata[4]};
    md = i_wdata[2:0];
    trp = int'(m_tim[23:20]); trc = int'(m_tim[15:12]); tmrd = int'(m_tim[3:0]);
    if (was_idle && i_wr && i_addr == 3'd2 && md != 3'd7 && hb != 2'b00) begin
      m_cmd = i_wdata & 32'h003F_FFFF;
      case (md)
        3'd1: begin m_cke = 1; issue(hb, 3'b111, 13'd0, 0, 0, "R5"); end
        3'd2: issue(hb, 3'b010, 13'h0400, trp, 0, "R6 R12");
        3'd3: issue(hb, 3'b001, 13'd0, trc + 1, int'(i_wdata[8:5]), "R7 R12");
        3'd4: issue(hb, 3'b000, i_wdata[21:9], tmrd, 0, "R8 R12");
        default: issue(hb, 3'b111, 13'd0, 0, 0, "R9");
      endcase
      m_norm = (md == 3'd0);
      if (md == 3'd0) m_nb = hb;
    end else if (was_idle && req) begin
      issue(m_nb, 3'b001, 13'd0, trc + 1, 0, "R10 R11");
    end
    if (i_wr) begin
      case (i_addr)
        3'd0: m_ctrl = i_wdata & 32'h0000_7FFF;
        3'd1: m_tim  = i_wdata & 32'h0FFF_FFFF;
        3'd3: m_refcnt = int'(i_wdata[14:1]);
        default: ;
      endcase
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return m_tim;
      3'd2: return m_cmd;
      3'd3: return 32'(m_refcnt) << 1;
      3'd4: return (q.size() != 0) ? 32'h20 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare();
    logic [17:0] e;
    string t;
    e = (q.size() != 0) ? q[0] : IDLE_PAT;
    t = (q.size() != 0) ? tq[0] : "R3 idle";
    check({t, " pins"}, 32'({cs_n, ras_n, cas_n, we_n, sdaddr}), 32'(e));
    check("R5 cke", 32'(cke), 32'(m_cke));
    check((i_addr == 3'd4) ? "R4 status" : "R2 readback", rdata, exp_rd(i_addr));
  endtask

  task automatic cyc(input bit wr, input logic [2:0] a, input logic [31:0] d);
    i_wr = wr; i_addr = a; i_wdata = d;
    @(negedge clk);
    model_edge();
    compare();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 3'd4, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pins", 32'({cs_n, ras_n, cas_n, we_n, sdaddr}), 32'(IDLE_PAT));
    check("R1 reset cke", 32'(cke), 32'h0);
    check("R1 refresh default", rdata, 32'd16392);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle(2);
    // R2 masking
    cyc(1, 3'd0, 32'hFFFF_FFFF); cyc(0, 3'd0, 0);
    cyc(1, 3'd3, 32'hFFFF_FFFF); cyc(0, 3'd3, 0);
    cyc(1, 3'd1, 32'hF020_3002); cyc(0, 3'd1, 0);
    // R5 clock enable, R3 ignored codes
    cyc(1, 3'd2, 32'h19); idle(3);
    cyc(1, 3'd2, 32'h02); idle(2);
    cyc(1, 3'd2, 32'h1F); idle(2);
    // R6 precharge on chip select 0 only; R4 write while busy ignored
    cyc(1, 3'd2, 32'h12); cyc(1, 3'd2, 32'h0B); idle(5);
    // R7 eight refreshes to both
    cyc(1, 3'd2, 32'hFB); idle(50);
    // R8 load mode, R12 timing write mid-sequence
    cyc(1, 3'd1, 32'h0020_3005);
    cyc(1, 3'd2, 32'h601C); cyc(1, 3'd1, 32'h0); idle(8);
    // R9 self-refresh / power-down codes
    cyc(1, 3'd2, 32'h0D); idle(2);
    cyc(1, 3'd2, 32'h16); idle(2);
    // back-to-back zero-wait commands (R4)
    cyc(1, 3'd2, 32'h1A); cyc(0, 3'd4, 0); cyc(1, 3'd2, 32'h1C); idle(3);
    // R10 periodic refresh, R11 collision
    cyc(1, 3'd1, 32'h0000_2000);
    cyc(1, 3'd3, 32'd40);
    cyc(1, 3'd2, 32'h08); idle(120);
    for (int k = 0; k < 4000; k++) begin
      int sel;
      logic [31:0] d;
      sel = $urandom_range(0, 9);
      d = $urandom();
      if (sel < 5)       cyc(1, 3'd2, d);
      else if (sel == 5) cyc(1, 3'd1, d);
      else if (sel == 6) cyc(1, 3'd3, 32'($urandom_range(0, 60)) << 1);
      else if (sel == 7) cyc(1, 3'(d[2:0]), d);
      else               cyc(0, 3'(d[2:0]), 0);
    end
    idle(400);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL R4 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule